// File: doc/BRIEF.md
# Session Framer with Flag Decoding and CRC-16 Blocks

This block sits between a single-wire token codec, which delivers and accepts whole bytes, and a command engine. In the idle awake state it reads each incoming byte as a one-byte flag: one flag value opens a command block, one asks for the current reply, one puts the session to sleep, and every other value is dropped. A command block is a length byte, a packet and a two-byte CRC. The framer checks the length range and the CRC, stores the packet in a shared I/O buffer and starts the engine. The engine reads its arguments from that buffer, writes its reply back into it and reports a result code.

When the host asks for a reply, the framer sends a complete block: a length byte, the packet and a CRC that it computes as the bytes leave. The packet is either a one-byte status code or the engine's reply. The framer also tracks the session state: asleep, awake, receiving, busy, paused or transmitting. A watchdog that starts at wake forces the session to sleep after a fixed number of cycles. Nothing restarts that count except a sleep followed by a new wake.

Top module: `sess_frame_ctl`

## Requirements
- R1: After reset the session is asleep (`sess_o` = 0), `eng_rst_o` is 1 and `tx_valid_o` is 0. A `wake_i` pulse while asleep moves the session to awake (`sess_o` = 1). The codes for `sess_o` are: 0 asleep, 1 awake, 2 receiving, 3 busy, 4 paused, 5 transmitting.
- R2: While awake, byte 0x77 enters receiving, byte 0x88 starts a reply, byte 0xCC enters sleep, and any other byte leaves the state unchanged and sends nothing.
- R3: A reply requested after wake and before any command is the block 0x04, 0x11, CRC low, CRC high. The CRC is CRC-16 with polynomial 0x8005 and start value 0. It covers the length and packet bytes and is fed each byte least significant bit first. Its low byte goes out first.
- R4: A block whose first byte N lies in 4..39 and whose CRC is correct ends after exactly N bytes. The framer then enters busy, pulses `cmd_start_o` for one cycle with `cmd_len_o` = N-3, and the packet bytes can be read from buffer addresses 0 upward.
- R5: A block with a wrong CRC starts nothing and returns the session to awake. The next reply is 0x04, 0xFF, CRC.
- R6: A length byte below 4 or above 39 ends the block at once and returns the session to awake. The next reply is 0x04, 0xFF, CRC.
- R7: While busy, a 0x88 flag sends nothing. When the engine reports success with a reply length L of 1..36, the reply is the block L+3, buffer bytes 0..L-1, CRC.
- R8: When the engine reports an execution error, the reply is 0x04, 0x0F, CRC.
- R9: Sending 0x88 again repeats the same reply block byte for byte.
- R10: When the engine reports the pause result, the session enters paused (4). Every input byte, including the sleep flag, is then ignored until the watchdog puts the session to sleep.
- R11: The session falls asleep exactly WDOG_CYC cycles after the wake edge, whatever the state. A `wake_i` pulse while awake does not restart the count.
- R12: An `io_timeout_i` pulse while awake or receiving discards any partial block and puts the session to sleep.
- R13: While asleep, `eng_rst_o` is 1 and the I/O buffer reads back as zero. After the next wake the reply is again the 0x11 block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wake_i | input | 1 | Wake event from the token codec |
| rx_valid_i | input | 1 | A received byte is present |
| rx_data_i | input | 8 | Received byte |
| io_timeout_i | input | 1 | Inter-token timeout from the token codec |
| tx_valid_o | output | 1 | An outgoing byte is offered |
| tx_data_o | output | 8 | Outgoing byte |
| tx_ready_i | input | 1 | Token codec accepts the outgoing byte |
| sess_o | output | 3 | Session state code |
| eng_rst_o | output | 1 | Reset for the command engine, held while asleep |
| cmd_start_o | output | 1 | One-cycle start pulse for the engine |
| cmd_len_o | output | 6 | Packet length of the accepted block |
| eng_addr_i | input | 6 | Engine buffer address |
| eng_rdata_o | output | 8 | Buffer byte at the engine address |
| eng_we_i | input | 1 | Engine buffer write, honoured while busy |
| eng_wdata_i | input | 8 | Engine write byte |
| eng_done_i | input | 1 | Engine has finished |
| eng_result_i | input | 2 | 0 success, 1 execution error, 2 pause, 3 execution error |
| eng_rsp_len_i | input | 6 | Reply packet length on success |

## Verification
A corrupted CRC register shows up on the ports at the end of the next block. A good block is refused with the 0xFF reply, or the CRC bytes of the next reply come out wrong, so every reply block is compared against a CRC the bench computes itself. A wrong byte index or length register shifts the end of a block. A busy state entered too early or too late moves the `cmd_start_o` pulse, which is sampled in the cycle right after the last byte. A watchdog fault shows as a sleep that arrives a cycle early or late, so the bench counts the cycle of that sleep exactly.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

    localparam logic [7:0]  FLG_CMD  = 8'h77;
    localparam logic [7:0]  FLG_XMT  = 8'h88;
    localparam logic [7:0]  FLG_SLP  = 8'hCC;
    localparam logic [7:0]  ST_WAKE  = 8'h11;
    localparam logic [7:0]  ST_BAD   = 8'hFF;
    localparam logic [7:0]  ST_EXEC  = 8'h0F;
    localparam logic [15:0] CRC_POLY = 16'h8005;

    typedef enum logic [2:0] {
        SS_SLEEP = 3'd0,
        SS_AWAKE = 3'd1,
        SS_RECV  = 3'd2,
        SS_BUSY  = 3'd3,
        SS_PAUSE = 3'd4,
        SS_TX    = 3'd5
    } sess_e;

    typedef enum logic [1:0] {
        RK_WAKE = 2'd0,
        RK_BAD  = 2'd1,
        RK_EXEC = 2'd2,
        RK_DATA = 2'd3
    } rsp_kind_e;

    typedef enum logic [1:0] {
        ER_OK    = 2'd0,
        ER_EXEC  = 2'd1,
        ER_PAUSE = 2'd2,
        ER_OTHER = 2'd3
    } eng_res_e;

    function automatic logic [15:0] crc_step_byte(input logic [15:0] cur, input logic [7:0] b);
        logic [15:0] r;
        logic        fb;
        r = cur;
        for (int i = 0; i < 8; i++) begin
            fb = b[i] ^ r[15];
            r  = {r[14:0], 1'b0};
            if (fb) r = r ^ CRC_POLY;
        end
        return r;
    endfunction

endpackage

// File: rtl/sfc_crc16.sv
module sfc_crc16 (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        clr_i,
    input  logic        en_i,
    input  logic [7:0]  byte_i,
    output logic [15:0] crc_o
);
    import sfc_pkg::*;

    logic [15:0] crc_d, crc_q;

    always_comb begin
        crc_d = crc_q;
        if (clr_i)     crc_d = 16'h0000;
        else if (en_i) crc_d = crc_step_byte(crc_q, byte_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) crc_q <= 16'h0000;
        else         crc_q <= crc_d;
    end

    assign crc_o = crc_q;
endmodule

// File: rtl/sfc_iobuf.sv
module sfc_iobuf #(
    parameter int DEPTH = 36,
    parameter int AW    = 6,
    parameter int DW    = 8
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          clr_i,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);
    logic [DW-1:0] mem_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)                               mem_q[g] <= '0;
            else if (clr_i)                            mem_q[g] <= '0;
            else if (we_i && (waddr_i == AW'(g)))      mem_q[g] <= wdata_i;
        end
    end

    always_comb begin
        rdata_o = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (raddr_i == AW'(i)) rdata_o = mem_q[i];
        end
    end
endmodule

// File: rtl/sfc_wdog.sv
module sfc_wdog #(
    parameter int LIMIT = 1000000,
    localparam int CW   = $clog2(LIMIT + 1)
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    output logic expire_o
);
    logic [CW-1:0] cnt_d, cnt_q;

    assign expire_o = run_i && (cnt_q == CW'(LIMIT - 1));

    always_comb begin
        cnt_d = cnt_q;
        if (!run_i)        cnt_d = '0;
        else if (!expire_o) cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end
endmodule

// File: rtl/sess_frame_ctl.sv
module sess_frame_ctl #(
    parameter int MIN_BLK  = 4,
    parameter int MAX_BLK  = 39,
    parameter int WDOG_CYC = 1000000,
    localparam int PKT_MAX = MAX_BLK - 3,
    localparam int LW      = $clog2(MAX_BLK + 1),
    localparam int AW      = $clog2(PKT_MAX)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          wake_i,
    input  logic          rx_valid_i,
    input  logic [7:0]    rx_data_i,
    input  logic          io_timeout_i,
    output logic          tx_valid_o,
    output logic [7:0]    tx_data_o,
    input  logic          tx_ready_i,
    output logic [2:0]    sess_o,
    output logic          eng_rst_o,
    output logic          cmd_start_o,
    output logic [LW-1:0] cmd_len_o,
    input  logic [AW-1:0] eng_addr_i,
    output logic [7:0]    eng_rdata_o,
    input  logic          eng_we_i,
    input  logic [7:0]    eng_wdata_i,
    input  logic          eng_done_i,
    input  logic [1:0]    eng_result_i,
    input  logic [LW-1:0] eng_rsp_len_i
);
    import sfc_pkg::*;

    typedef struct packed {
        sess_e     state;
        logic [LW-1:0] idx;
        logic [LW-1:0] n;
        rsp_kind_e rkind;
        logic [LW-1:0] rlen;
        logic      lo_ok;
        logic      cmd_start;
        logic [LW-1:0] cmd_len;
    } regs_t;

    localparam regs_t REGS_RST = '{
        state:     SS_SLEEP,
        idx:       '0,
        n:         '0,
        rkind:     RK_WAKE,
        rlen:      '0,
        lo_ok:     1'b0,
        cmd_start: 1'b0,
        cmd_len:   '0
    };

    regs_t d, q;

    logic          crc_clr, crc_en;
    logic [7:0]    crc_in;
    logic [15:0]   crc_val;
    logic          bw_en;
    logic [AW-1:0] bw_addr;
    logic [7:0]    bw_data;
    logic [AW-1:0] br_addr;
    logic [7:0]    br_data;
    logic          wd_expire;
    logic [LW-1:0] tx_tot;
    logic [7:0]    tx_byte;
    logic [LW-1:0] pkt_last;

    sfc_crc16 i_crc (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (crc_clr),
        .en_i   (crc_en),
        .byte_i (crc_in),
        .crc_o  (crc_val)
    );

    sfc_iobuf #(.DEPTH(PKT_MAX), .AW(AW), .DW(8)) i_buf (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clr_i   (q.state == SS_SLEEP),
        .we_i    (bw_en),
        .waddr_i (bw_addr),
        .wdata_i (bw_data),
        .raddr_i (br_addr),
        .rdata_o (br_data)
    );

    sfc_wdog #(.LIMIT(WDOG_CYC)) i_wdog (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .run_i    (q.state != SS_SLEEP),
        .expire_o (wd_expire)
    );

    // Outgoing byte selection: length, packet or status, then the two CRC bytes
    always_comb begin
        tx_tot  = (q.rkind == RK_DATA) ? (q.rlen + LW'(3)) : LW'(4);
        br_addr = (q.state == SS_TX) ? AW'(q.idx - LW'(1)) : eng_addr_i;
        if (q.idx == '0) begin
            tx_byte = 8'(tx_tot);
        end else if (q.idx == tx_tot - LW'(2)) begin
            tx_byte = crc_val[7:0];
        end else if (q.idx == tx_tot - LW'(1)) begin
            tx_byte = crc_val[15:8];
        end else begin
            unique case (q.rkind)
                RK_WAKE: tx_byte = ST_WAKE;
                RK_BAD:  tx_byte = ST_BAD;
                RK_EXEC: tx_byte = ST_EXEC;
                default: tx_byte = br_data;
            endcase
        end
    end

    assign pkt_last = q.n - LW'(3);

    always_comb begin
        d           = q;
        d.cmd_start = 1'b0;
        crc_clr     = 1'b0;
        crc_en      = 1'b0;
        crc_in      = rx_data_i;
        bw_en       = 1'b0;
        bw_addr     = AW'(q.idx - LW'(1));
        bw_data     = rx_data_i;

        unique case (q.state)
            SS_SLEEP: begin
                if (wake_i) begin
                    d.state = SS_AWAKE;
                    d.rkind = RK_WAKE;
                    d.idx   = '0;
                end
            end
            SS_AWAKE: begin
                if (io_timeout_i) begin
                    d.state = SS_SLEEP;
                end else if (rx_valid_i) begin
                    if (rx_data_i == FLG_CMD) begin
                        d.state = SS_RECV;
                        d.idx   = '0;
                        crc_clr = 1'b1;
                    end else if (rx_data_i == FLG_XMT) begin
                        d.state = SS_TX;
                        d.idx   = '0;
                        crc_clr = 1'b1;
                    end else if (rx_data_i == FLG_SLP) begin
                        d.state = SS_SLEEP;
                    end
                end
            end
            SS_RECV: begin
                if (io_timeout_i) begin
                    d.state = SS_SLEEP;
                end else if (rx_valid_i) begin
                    if (q.idx == '0) begin
                        if ((rx_data_i < 8'(MIN_BLK)) || (rx_data_i > 8'(MAX_BLK))) begin
                            d.rkind = RK_BAD;
                            d.state = SS_AWAKE;
                        end else begin
                            d.n    = LW'(rx_data_i);
                            d.idx  = LW'(1);
                            crc_en = 1'b1;
                        end
                    end else if (q.idx <= pkt_last) begin
                        bw_en  = 1'b1;
                        crc_en = 1'b1;
                        d.idx  = q.idx + LW'(1);
                    end else if (q.idx == pkt_last + LW'(1)) begin
                        d.lo_ok = (rx_data_i == crc_val[7:0]);
                        d.idx   = q.idx + LW'(1);
                    end else begin
                        d.idx = '0;
                        if (q.lo_ok && (rx_data_i == crc_val[15:8])) begin
                            d.state     = SS_BUSY;
                            d.cmd_start = 1'b1;
                            d.cmd_len   = pkt_last;
                        end else begin
                            d.rkind = RK_BAD;
                            d.state = SS_AWAKE;
                        end
                    end
                end
            end
            SS_BUSY: begin
                bw_en   = eng_we_i;
                bw_addr = eng_addr_i;
                bw_data = eng_wdata_i;
                if (eng_done_i) begin
                    d.state = SS_AWAKE;
                    unique case (eng_res_e'(eng_result_i))
                        ER_OK: begin
                            if ((eng_rsp_len_i != '0) && (eng_rsp_len_i <= LW'(PKT_MAX))) begin
                                d.rkind = RK_DATA;
                                d.rlen  = eng_rsp_len_i;
                            end else begin
                                d.rkind = RK_EXEC;
                            end
                        end
                        ER_PAUSE: d.state = SS_PAUSE;
                        default:  d.rkind = RK_EXEC;
                    endcase
                end
            end
            SS_PAUSE: begin
                d.state = SS_PAUSE;
            end
            SS_TX: begin
                if (tx_ready_i) begin
                    crc_in = tx_byte;
                    if (q.idx < tx_tot - LW'(2)) crc_en = 1'b1;
                    if (q.idx == tx_tot - LW'(1)) begin
                        d.state = SS_AWAKE;
                        d.idx   = '0;
                    end else begin
                        d.idx = q.idx + LW'(1);
                    end
                end
            end
            default: d.state = SS_SLEEP;
        endcase

        if (wd_expire) d.state = SS_SLEEP;

        if ((d.state == SS_SLEEP) && (q.state != SS_SLEEP)) begin
            d = REGS_RST;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= REGS_RST;
        else         q <= d;
    end

    assign tx_valid_o  = (q.state == SS_TX);
    assign tx_data_o   = tx_byte;
    assign sess_o      = q.state;
    assign eng_rst_o   = (q.state == SS_SLEEP);
    assign cmd_start_o = q.cmd_start;
    assign cmd_len_o   = q.cmd_len;
    assign eng_rdata_o = br_data;
endmodule

// File: rtl/sfc_checker.sv
module sfc_checker #(
    parameter int WDOG_CYC = 1000000,
    parameter int PKT_MAX  = 36,
    parameter int LW       = 6
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          wake_i,
    input logic [2:0]    sess_o,
    input logic          tx_valid_o,
    input logic          tx_ready_i,
    input logic [7:0]    tx_data_o,
    input logic          cmd_start_o,
    input logic [LW-1:0] cmd_len_o
);
    import sfc_pkg::*;

    logic [31:0] awake_cnt;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                     awake_cnt <= '0;
        else if (sess_o == 3'(SS_SLEEP)) awake_cnt <= '0;
        else                             awake_cnt <= awake_cnt + 32'd1;
    end

    AST_WAKE_FROM_SLEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(sess_o) == 3'(SS_SLEEP) && sess_o != 3'(SS_SLEEP)) |-> $past(wake_i)); // R1

    AST_START_AFTER_RECV: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmd_start_o |-> (sess_o == 3'(SS_BUSY) && $past(sess_o) == 3'(SS_RECV))); // R4

    AST_CMD_LEN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmd_start_o |-> (cmd_len_o >= LW'(1) && cmd_len_o <= LW'(PKT_MAX))); // R4

    AST_BUSY_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sess_o == 3'(SS_BUSY)) |-> !tx_valid_o); // R7

    AST_TX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tx_valid_o && !tx_ready_i) |=> (!tx_valid_o || $stable(tx_data_o))); // R3

    AST_PAUSE_EXIT_SLEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(sess_o) == 3'(SS_PAUSE) && sess_o != 3'(SS_PAUSE)) |-> (sess_o == 3'(SS_SLEEP))); // R10

    AST_WDOG_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sess_o != 3'(SS_SLEEP)) |-> (awake_cnt < 32'(WDOG_CYC))); // R11
endmodule

bind sess_frame_ctl sfc_checker #(
    .WDOG_CYC (WDOG_CYC),
    .PKT_MAX  (PKT_MAX),
    .LW       (LW)
) i_sfc_checker (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wake_i      (wake_i),
    .sess_o      (sess_o),
    .tx_valid_o  (tx_valid_o),
    .tx_ready_i  (tx_ready_i),
    .tx_data_o   (tx_data_o),
    .cmd_start_o (cmd_start_o),
    .cmd_len_o   (cmd_len_o)
);

// File: tb/test_sess_frame_ctl.sv
module test_sess_frame_ctl;
    localparam int W = 3000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wake_i = 1'b0;
    logic       rx_valid_i = 1'b0;
    logic [7:0] rx_data_i = 8'h00;
    logic       io_timeout_i = 1'b0;
    logic       tx_valid_o;
    logic [7:0] tx_data_o;
    logic       tx_ready_i = 1'b1;
    logic [2:0] sess_o;
    logic       eng_rst_o;
    logic       cmd_start_o;
    logic [5:0] cmd_len_o;
    logic [5:0] eng_addr_i = 6'd0;
    logic [7:0] eng_rdata_o;
    logic       eng_we_i = 1'b0;
    logic [7:0] eng_wdata_i = 8'h00;
    logic       eng_done_i = 1'b0;
    logic [1:0] eng_result_i = 2'd0;
    logic [5:0] eng_rsp_len_i = 6'd0;

    int nchk = 0;
    int nbad = 0;
    logic [7:0] rb [0:63];
    int rn;

    always #2.5 clk = ~clk;

    sess_frame_ctl #(.WDOG_CYC(W)) i_sess_frame_ctl (
        .clk_i(clk), .rst_ni(rst_n), .wake_i(wake_i),
        .rx_valid_i(rx_valid_i), .rx_data_i(rx_data_i), .io_timeout_i(io_timeout_i),
        .tx_valid_o(tx_valid_o), .tx_data_o(tx_data_o), .tx_ready_i(tx_ready_i),
        .sess_o(sess_o), .eng_rst_o(eng_rst_o), .cmd_start_o(cmd_start_o),
        .cmd_len_o(cmd_len_o), .eng_addr_i(eng_addr_i), .eng_rdata_o(eng_rdata_o),
        .eng_we_i(eng_we_i), .eng_wdata_i(eng_wdata_i), .eng_done_i(eng_done_i),
        .eng_result_i(eng_result_i), .eng_rsp_len_i(eng_rsp_len_i)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_crc(input logic [7:0] m [0:63], input int n);
        logic [15:0] r = 16'h0;
        for (int j = 0; j < n; j++) begin
            for (int b = 0; b < 8; b++) begin
                if (m[j][b] != r[15]) r = (r << 1) ^ 16'h8005;
                else                  r = r << 1;
            end
        end
        return r;
    endfunction

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        rx_valid_i = 1'b1;
        rx_data_i  = b;
        @(negedge clk);
        rx_valid_i = 1'b0;
    endtask

    task automatic new_session();
        if (sess_o == 3'd1) send_byte(8'hCC);
        @(negedge clk);
        wake_i = 1'b1;
        @(negedge clk);
        wake_i = 1'b0;
        check(sess_o == 3'd1, "R1 wake", sess_o, 1);
    endtask

    task automatic get_block();
        send_byte(8'h88);
        rn = 0;
        for (int k = 0; k < 120; k++) begin
            if (rn > 0 && rn == int'(rb[0])) break;
            if (tx_valid_o) begin
                rb[rn] = tx_data_o;
                rn++;
            end
            @(negedge clk);
        end
    endtask

    task automatic expect_status(input logic [7:0] code, input string req);
        logic [7:0] m [0:63];
        logic [15:0] c;
        get_block();
        m[0] = 8'h04; m[1] = code;
        c = ref_crc(m, 2);
        check(rn == 4, req, rn, 4);
        check(rb[1] == code, req, rb[1], code);
        check(rb[2] == c[7:0] && rb[3] == c[15:8], req, {rb[3], rb[2]}, c);
    endtask

    task automatic send_block(input logic [7:0] p [0:63], input int plen, input bit corrupt);
        logic [7:0] m [0:63];
        logic [15:0] c;
        m[0] = 8'(plen + 3);
        for (int i = 0; i < plen; i++) m[i+1] = p[i];
        c = ref_crc(m, plen + 1);
        if (corrupt) c = c ^ 16'h0100;
        send_byte(8'h77);
        for (int i = 0; i <= plen; i++) send_byte(m[i]);
        send_byte(c[7:0]);
        send_byte(c[15:8]);
    endtask

    task automatic eng_finish(input logic [1:0] res, input int len, input logic [7:0] seed);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            eng_we_i = 1'b1; eng_addr_i = 6'(i); eng_wdata_i = seed + 8'(i);
        end
        @(negedge clk);
        eng_we_i = 1'b0;
        eng_done_i = 1'b1; eng_result_i = res; eng_rsp_len_i = 6'(len);
        @(negedge clk);
        eng_done_i = 1'b0;
    endtask

    task automatic t_reset();
        check(sess_o == 3'd0, "R1 reset sess", sess_o, 0);
        check(eng_rst_o == 1'b1, "R1 reset eng_rst", eng_rst_o, 1);
        check(tx_valid_o == 1'b0, "R1 reset tx_valid", tx_valid_o, 0);
    endtask

    task automatic t_wake_status();
        new_session();
        expect_status(8'h11, "R3 wake status");
        expect_status(8'h11, "R9 reread wake status");
    endtask

    task automatic t_flags();
        bit seen = 0;
        new_session();
        send_byte(8'h12);
        send_byte(8'h00);
        for (int k = 0; k < 4; k++) begin @(negedge clk); if (tx_valid_o) seen = 1; end
        check(sess_o == 3'd1 && !seen, "R2 reserved flag ignored", sess_o, 1);
        send_byte(8'h77);
        check(sess_o == 3'd2, "R2 command flag", sess_o, 2);
        @(negedge clk);
        io_timeout_i = 1'b1;
        @(negedge clk);
        io_timeout_i = 1'b0;
        check(sess_o == 3'd0, "R12 timeout in receive", sess_o, 0);
        new_session();
        send_byte(8'hCC);
        check(sess_o == 3'd0, "R2 sleep flag", sess_o, 0);
    endtask

    task automatic t_cmd_ok();
        logic [7:0] p [0:63];
        logic [7:0] m [0:63];
        logic [15:0] c;
        bit seen = 0;
        new_session();
        p[0] = 8'h08; p[1] = 8'h50; p[2] = 8'hFF; p[3] = 8'hFF;
        send_block(p, 4, 1'b0);
        check(cmd_start_o == 1'b1, "R4 start pulse", cmd_start_o, 1);
        check(cmd_len_o == 6'd4, "R4 packet length", cmd_len_o, 4);
        check(sess_o == 3'd3, "R4 busy", sess_o, 3);
        @(negedge clk);
        check(cmd_start_o == 1'b0, "R4 single pulse", cmd_start_o, 0);
        for (int i = 0; i < 4; i++) begin
            eng_addr_i = 6'(i);
            #1;
            check(eng_rdata_o == p[i], "R4 packet byte", eng_rdata_o, p[i]);
        end
        send_byte(8'h88);
        for (int k = 0; k < 6; k++) begin @(negedge clk); if (tx_valid_o) seen = 1; end
        check(!seen && sess_o == 3'd3, "R7 transmit ignored while busy", seen, 0);
        eng_finish(2'd0, 5, 8'hA0);
        check(sess_o == 3'd1, "R7 awake after done", sess_o, 1);
        get_block();
        m[0] = 8'd8;
        for (int i = 0; i < 5; i++) m[i+1] = 8'hA0 + 8'(i);
        c = ref_crc(m, 6);
        check(rn == 8, "R7 reply length", rn, 8);
        for (int i = 0; i < 6; i++) check(rb[i] == m[i], "R7 reply byte", rb[i], m[i]);
        check(rb[6] == c[7:0] && rb[7] == c[15:8], "R7 reply crc", {rb[7], rb[6]}, c);
        get_block();
        check(rn == 8 && rb[5] == 8'hA4 && rb[6] == c[7:0] && rb[7] == c[15:8],
              "R9 reread data reply", {rb[7], rb[6]}, c);
    endtask

    task automatic t_cmd_max();
        logic [7:0] p [0:63];
        new_session();
        for (int i = 0; i < 36; i++) p[i] = 8'h30 + 8'(i);
        send_block(p, 36, 1'b0);
        check(cmd_start_o == 1'b1 && cmd_len_o == 6'd36, "R4 largest block", cmd_len_o, 36);
        eng_addr_i = 6'd35;
        #1;
        check(eng_rdata_o == 8'h53, "R4 last packet byte", eng_rdata_o, 8'h53);
        eng_finish(2'd1, 0, 8'h00);
        expect_status(8'h0F, "R8 execution error");
    endtask

    task automatic t_bad_crc();
        logic [7:0] p [0:63];
        new_session();
        p[0] = 8'h02; p[1] = 8'h00;
        send_block(p, 2, 1'b1);
        check(cmd_start_o == 1'b0, "R5 no start on bad crc", cmd_start_o, 0);
        check(sess_o == 3'd1, "R5 back to awake", sess_o, 1);
        expect_status(8'hFF, "R5 crc error status");
    endtask

    task automatic t_bad_count();
        new_session();
        send_byte(8'h77);
        send_byte(8'h03);
        check(sess_o == 3'd1, "R6 short count", sess_o, 1);
        expect_status(8'hFF, "R6 short count status");
        send_byte(8'h77);
        send_byte(8'd40);
        check(sess_o == 3'd1, "R6 long count", sess_o, 1);
        expect_status(8'hFF, "R6 long count status");
    endtask

    task automatic t_timeout();
        new_session();
        send_byte(8'h77);
        send_byte(8'h07);
        send_byte(8'h01);
        send_byte(8'h02);
        @(negedge clk);
        io_timeout_i = 1'b1;
        @(negedge clk);
        io_timeout_i = 1'b0;
        check(sess_o == 3'd0, "R12 partial block dropped", sess_o, 0);
        new_session();
        expect_status(8'h11, "R12 fresh status after timeout");
    endtask

    task automatic t_sleep_clear();
        logic [7:0] p [0:63];
        new_session();
        p[0] = 8'hAA; p[1] = 8'hBB;
        send_block(p, 2, 1'b0);
        eng_finish(2'd0, 2, 8'h5A);
        send_byte(8'hCC);
        check(eng_rst_o == 1'b1, "R13 engine reset in sleep", eng_rst_o, 1);
        eng_addr_i = 6'd0;
        @(negedge clk);
        #1;
        check(eng_rdata_o == 8'h00, "R13 buffer cleared", eng_rdata_o, 0);
        new_session();
        check(eng_rst_o == 1'b0, "R13 engine released", eng_rst_o, 0);
        expect_status(8'h11, "R13 status after sleep");
    endtask

    task automatic t_pause();
        logic [7:0] p [0:63];
        bit seen = 0;
        int k;
        new_session();
        p[0] = 8'h01; p[1] = 8'h02;
        send_block(p, 2, 1'b0);
        eng_finish(2'd2, 0, 8'h00);
        check(sess_o == 3'd4, "R10 paused", sess_o, 4);
        send_byte(8'hCC);
        check(sess_o == 3'd4, "R10 sleep flag ignored", sess_o, 4);
        send_byte(8'h88);
        for (int j = 0; j < 5; j++) begin @(negedge clk); if (tx_valid_o) seen = 1; end
        check(!seen, "R10 transmit ignored in pause", seen, 0);
        k = 0;
        while (sess_o == 3'd4 && k < W + 10) begin @(negedge clk); k++; end
        check(sess_o == 3'd0, "R10 pause ends in sleep", sess_o, 0);
    endtask

    task automatic t_wdog();
        int k = 0;
        @(negedge clk);
        wake_i = 1'b1;
        @(negedge clk);
        wake_i = 1'b0;
        while (sess_o != 3'd0 && k < W + 10) begin
            @(negedge clk);
            k++;
            if (k == 1000) wake_i = 1'b1;
            if (k == 1001) wake_i = 1'b0;
        end
        check(k == W, "R11 watchdog cycle count", k, W);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_wake_status();
        t_flags();
        t_cmd_ok();
        t_cmd_max();
        t_bad_crc();
        t_bad_count();
        t_timeout();
        t_sleep_clear();
        t_pause();
        t_wdog();
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        nchk++;
        nbad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end
endmodule